// File: doc/BRIEF.md
# Timer Interrupt Status Controller

This block sits beside a multi-mode function timer. It gathers the single-cycle event strobes that the timer core raises and holds them as sticky status bits. From those bits it builds one level interrupt request and a one-clock trigger pulse that can start another timer or an ADC conversion. The event strobes cover period match, compare match and capture on two channels, trigger start, trigger stop and emergency stop. The counter, comparators, capture registers and PWM logic are outside this block.

The timer's operating mode decides what each channel status records. In compare-based modes, channels A and B latch compare matches. In capture mode they latch capture events instead, and reading the matching capture data register clears them as well. Software uses a small write-only register bus to do three things: program the interrupt enables and the trigger-source enables, clear status bits by writing ones, and acknowledge the end of interrupt service. The emergency stop interrupt has no enable bit of its own. It follows the timer's emergency-stop function enable.

Top module: `ftm_irq_ctrl`

## Requirements
- R1: After synchronous reset, `status_o`, `irq_o` and `trig_o` are all zero, and all interrupt and trigger enables are zero.
- R2: A period-match strobe sets status bit 0 on the next clock in every mode. Mode codes are 0 timer, 1 PWM1, 2 PWM2, 3 capture.
- R3: Status bit 1 (channel A) is set by compare match A in modes 0, 1 and 2, and by capture A in mode 3. The other event of the pair is ignored.
- R4: Status bit 2 (channel B) is set by compare match B in modes 0 and 1, and by capture B in mode 3. In mode 2 nothing sets it.
- R5: A bus write to address 1 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: In mode 3 only, a capture-A read strobe clears status bit 1 and a capture-B read strobe clears status bit 2. In other modes the strobes have no effect.
- R7: `irq_o` is high when any status bit 0 to 4 is set and its enable is set. The enables are written at address 0, data bits 0 to 4, in status-bit order.
- R8: Status bit 5 (emergency stop) contributes to `irq_o` exactly when `estop_func_en_i` is high. No enable register bit applies to it.
- R9: A bus write at address 3 with data bit 0 set forces `irq_o` low for the following cycle. The request then rises again if an enabled status bit is still set. A write there with bit 0 clear does nothing.
- R10: `trig_o` is a one-clock pulse in the cycle after a selected event. The selection is written at address 2: bit 0 period match, bit 1 compare A (modes 0 to 2), bit 2 compare B (modes 0 and 1).
- R11: When an event and a clear for the same status bit fall in the same cycle, the bit ends set.
- R12: Trigger-stop and trigger-start strobes set status bits 3 and 4 respectively in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Timer operating mode |
| ev_period_i | input | 1 | Period match strobe |
| ev_cmp_a_i | input | 1 | Compare A match strobe |
| ev_cmp_b_i | input | 1 | Compare B match strobe |
| ev_cap_a_i | input | 1 | Capture A strobe |
| ev_cap_b_i | input | 1 | Capture B strobe |
| ev_trig_start_i | input | 1 | Trigger start strobe |
| ev_trig_stop_i | input | 1 | Trigger stop strobe |
| ev_estop_i | input | 1 | Emergency stop strobe |
| estop_func_en_i | input | 1 | Emergency stop function enabled |
| cap_a_read_i | input | 1 | Capture A data register read strobe |
| cap_b_read_i | input | 1 | Capture B data register read strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Register write data |
| status_o | output | 6 | Status bits (0 period, 1 A, 2 B, 3 trig stop, 4 trig start, 5 emergency stop) |
| irq_o | output | 1 | Level interrupt request |
| trig_o | output | 1 | Trigger pulse to other peripherals |

## Verification
The assertions check four rules on every cycle: a set event always leaves its status bit high, a clear with no matching event drops the bit, the acknowledge masks the request for one cycle, and the trigger stays quiet when no source event occurs. They also check that channel B stays low in PWM2 mode and that a capture read clears its status in capture mode. The bench's scenarios are needed to show the mode-dependent choice between compare and capture, that zero bits in a clear write are ignored, and the gating by the enable register and the emergency-stop function enable. They also show the request coming back after an acknowledge and the trigger selection under each enable pattern. A behavioural model is compared against the outputs after every clock.

// File: rtl/ftm_irq_pkg.sv
package ftm_irq_pkg;

    localparam int NSRC   = 6;
    localparam int NEN    = NSRC - 1;
    localparam int NTRIG  = 3;
    localparam int ADDR_W = 2;

    localparam int SRC_PER    = 0;
    localparam int SRC_A      = 1;
    localparam int SRC_B      = 2;
    localparam int SRC_TSTOP  = 3;
    localparam int SRC_TSTART = 4;
    localparam int SRC_ESTOP  = 5;

    localparam int TRG_PER = 0;
    localparam int TRG_A   = 1;
    localparam int TRG_B   = 2;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_PWM1    = 2'd1,
        MODE_PWM2    = 2'd2,
        MODE_CAPTURE = 2'd3
    } tmr_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE  = 2'd0,
        REG_CLEAR   = 2'd1,
        REG_TRIGSEL = 2'd2,
        REG_ACK     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic period;
        logic cmp_a;
        logic cmp_b;
        logic cap_a;
        logic cap_b;
        logic trig_start;
        logic trig_stop;
        logic estop;
    } tmr_evt_t;

    function automatic logic chan_a_compare(tmr_mode_e m);
        return m != MODE_CAPTURE;
    endfunction

    function automatic logic chan_b_compare(tmr_mode_e m);
        return (m == MODE_TIMER) || (m == MODE_PWM1);
    endfunction

    function automatic logic is_capture(tmr_mode_e m);
        return m == MODE_CAPTURE;
    endfunction

endpackage

// File: rtl/ftm_irq_regs.sv
module ftm_irq_regs
    import ftm_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NEN-1:0]    en_q,
    output logic [NTRIG-1:0]  toe_q,
    output logic [NSRC-1:0]   wclr,
    output logic              ack_p
);

    reg_sel_e sel;
    logic     unused_hi;

    assign sel = reg_sel_e'(addr);

    generate
        if (DATA_W > NSRC) begin : g_hi
            assign unused_hi = ^wdata[DATA_W-1:NSRC];
        end else begin : g_nohi
            assign unused_hi = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            toe_q <= '0;
        end else if (we) begin
            case (sel)
                REG_ENABLE:  en_q  <= wdata[NEN-1:0];
                REG_TRIGSEL: toe_q <= wdata[NTRIG-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        wclr  = '0;
        ack_p = 1'b0;
        if (we && sel == REG_CLEAR) wclr = wdata[NSRC-1:0];
        if (we && sel == REG_ACK)   ack_p = wdata[0];
    end

endmodule

// File: rtl/ftm_irq_qual.sv
module ftm_irq_qual
    import ftm_irq_pkg::*;
(
    input  tmr_mode_e         mode,
    input  tmr_evt_t          evt,
    input  logic              rd_a,
    input  logic              rd_b,
    output logic [NSRC-1:0]   set_v,
    output logic [NSRC-1:0]   rdclr_v,
    output logic [NTRIG-1:0]  trig_src
);

    always_comb begin
        set_v             = '0;
        set_v[SRC_PER]    = evt.period;
        set_v[SRC_A]      = is_capture(mode) ? evt.cap_a : (chan_a_compare(mode) & evt.cmp_a);
        set_v[SRC_B]      = is_capture(mode) ? evt.cap_b : (chan_b_compare(mode) & evt.cmp_b);
        set_v[SRC_TSTOP]  = evt.trig_stop;
        set_v[SRC_TSTART] = evt.trig_start;
        set_v[SRC_ESTOP]  = evt.estop;

        rdclr_v           = '0;
        rdclr_v[SRC_A]    = is_capture(mode) & rd_a;
        rdclr_v[SRC_B]    = is_capture(mode) & rd_b;

        trig_src          = '0;
        trig_src[TRG_PER] = evt.period;
        trig_src[TRG_A]   = chan_a_compare(mode) & evt.cmp_a;
        trig_src[TRG_B]   = chan_b_compare(mode) & evt.cmp_b;
    end

endmodule

// File: rtl/ftm_irq_status.sv
module ftm_irq_status
    import ftm_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] st_q
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)           st_q[i] <= 1'b0;
                else if (set_v[i]) st_q[i] <= 1'b1;
                else if (clr_v[i]) st_q[i] <= 1'b0;
            end

            a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
                set_v[i] |=> st_q[i]);
            a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
                (clr_v[i] && !set_v[i]) |=> !st_q[i]);
            a_r5_hold_quiet: assert property (@(posedge clk) disable iff (rst)
                (!set_v[i] && !clr_v[i]) |=> $stable(st_q[i]));
        end
    endgenerate

endmodule

// File: rtl/ftm_irq_out.sv
module ftm_irq_out
    import ftm_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  st_q,
    input  logic [NEN-1:0]   en_q,
    input  logic             estop_en,
    input  logic [NTRIG-1:0] toe_q,
    input  logic [NTRIG-1:0] trig_src,
    input  logic             ack_p,
    output logic             irq,
    output logic             trig
);

    logic            ack_hold;
    logic [NSRC-1:0] en_eff;

    assign en_eff = {estop_en, en_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_hold <= 1'b0;
            trig     <= 1'b0;
        end else begin
            ack_hold <= ack_p;
            trig     <= |(trig_src & toe_q);
        end
    end

    assign irq = (|(st_q & en_eff)) & ~ack_hold;

    a_r9_ack_masks: assert property (@(posedge clk) disable iff (rst)
        ack_p |=> !irq);
    a_r10_trig_quiet: assert property (@(posedge clk) disable iff (rst)
        (trig_src == '0) |=> !trig);
    a_r8_estop_raises: assert property (@(posedge clk) disable iff (rst)
        (st_q[SRC_ESTOP] && estop_en && !ack_hold) |-> irq);

endmodule

// File: rtl/ftm_irq_ctrl.sv
module ftm_irq_ctrl
    import ftm_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              ev_period_i,
    input  logic              ev_cmp_a_i,
    input  logic              ev_cmp_b_i,
    input  logic              ev_cap_a_i,
    input  logic              ev_cap_b_i,
    input  logic              ev_trig_start_i,
    input  logic              ev_trig_stop_i,
    input  logic              ev_estop_i,
    input  logic              estop_func_en_i,
    input  logic              cap_a_read_i,
    input  logic              cap_b_read_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [5:0]        status_o,
    output logic              irq_o,
    output logic              trig_o
);

    tmr_mode_e        mode;
    tmr_evt_t         evt;
    logic [NEN-1:0]   en_q;
    logic [NTRIG-1:0] toe_q;
    logic [NSRC-1:0]  wclr;
    logic             ack_p;
    logic [NSRC-1:0]  set_v;
    logic [NSRC-1:0]  rdclr_v;
    logic [NSRC-1:0]  clr_v;
    logic [NTRIG-1:0] trig_src;
    logic [NSRC-1:0]  st_q;

    assign mode = tmr_mode_e'(mode_i);

    always_comb begin
        evt.period     = ev_period_i;
        evt.cmp_a      = ev_cmp_a_i;
        evt.cmp_b      = ev_cmp_b_i;
        evt.cap_a      = ev_cap_a_i;
        evt.cap_b      = ev_cap_b_i;
        evt.trig_start = ev_trig_start_i;
        evt.trig_stop  = ev_trig_stop_i;
        evt.estop      = ev_estop_i;
    end

    ftm_irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we_i),
        .addr  (bus_addr_i),
        .wdata (bus_wdata_i),
        .en_q  (en_q),
        .toe_q (toe_q),
        .wclr  (wclr),
        .ack_p (ack_p)
    );

    ftm_irq_qual u_qual (
        .mode     (mode),
        .evt      (evt),
        .rd_a     (cap_a_read_i),
        .rd_b     (cap_b_read_i),
        .set_v    (set_v),
        .rdclr_v  (rdclr_v),
        .trig_src (trig_src)
    );

    assign clr_v = wclr | rdclr_v;

    ftm_irq_status #(.N(NSRC)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .st_q  (st_q)
    );

    ftm_irq_out u_out (
        .clk      (clk),
        .rst      (rst),
        .st_q     (st_q),
        .en_q     (en_q),
        .estop_en (estop_func_en_i),
        .toe_q    (toe_q),
        .trig_src (trig_src),
        .ack_p    (ack_p),
        .irq      (irq_o),
        .trig     (trig_o)
    );

    assign status_o = st_q;

    a_r4_pwm2_b_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM2 && !status_o[SRC_B]) |=> !status_o[SRC_B]);
    a_r6_read_clears_a: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CAPTURE && cap_a_read_i && !ev_cap_a_i) |=> !status_o[SRC_A]);
    a_r6_read_clears_b: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CAPTURE && cap_b_read_i && !ev_cap_b_i) |=> !status_o[SRC_B]);
    a_r1_quiet_status: assert property (@(posedge clk) disable iff (rst)
        (status_o == '0) |-> !irq_o);

endmodule

// File: tb/ftm_irq_ctrl_bench.sv
module ftm_irq_ctrl_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic ev_period = 0, ev_cmp_a = 0, ev_cmp_b = 0, ev_cap_a = 0, ev_cap_b = 0;
    logic ev_tstart = 0, ev_tstop = 0, ev_estop = 0, estop_en = 0;
    logic rd_a = 0, rd_b = 0;
    logic       we = 0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [5:0] status;
    logic       irq, trig;

    ftm_irq_ctrl u_ftm_irq_ctrl (
        .clk(clk), .rst(rst), .mode_i(mode),
        .ev_period_i(ev_period), .ev_cmp_a_i(ev_cmp_a), .ev_cmp_b_i(ev_cmp_b),
        .ev_cap_a_i(ev_cap_a), .ev_cap_b_i(ev_cap_b),
        .ev_trig_start_i(ev_tstart), .ev_trig_stop_i(ev_tstop), .ev_estop_i(ev_estop),
        .estop_func_en_i(estop_en), .cap_a_read_i(rd_a), .cap_b_read_i(rd_b),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .status_o(status), .irq_o(irq), .trig_o(trig)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit [5:0] m_st;
    bit [4:0] m_en;
    bit [2:0] m_toe;
    bit       m_ack, m_trig;

    task automatic cycle();
        bit [5:0] s, c;
        bit exp_irq;
        @(posedge clk);
        if (rst) begin
            m_st = 0; m_en = 0; m_toe = 0; m_ack = 0; m_trig = 0;
        end else begin
            s = 0; c = 0;
            s[0] = ev_period;
            if (mode == 3) s[1] = ev_cap_a; else s[1] = ev_cmp_a;
            if (mode == 3) s[2] = ev_cap_b; else if (mode != 2) s[2] = ev_cmp_b;
            s[3] = ev_tstop; s[4] = ev_tstart; s[5] = ev_estop;
            if (we && addr == 1) c = wdata[5:0];
            if (mode == 3 && rd_a) c[1] = 1;
            if (mode == 3 && rd_b) c[2] = 1;
            m_trig = (ev_period && m_toe[0]) || (ev_cmp_a && mode != 3 && m_toe[1]) ||
                     (ev_cmp_b && mode < 2 && m_toe[2]);
            m_ack = we && addr == 3 && wdata[0];
            if (we && addr == 0) m_en = wdata[4:0];
            if (we && addr == 2) m_toe = wdata[2:0];
            m_st = s | (m_st & ~c);
        end
        #1;
        exp_irq = ((m_st & {estop_en, m_en}) != 0) && !m_ack;
        n_vec++;
        if (status !== m_st || irq !== exp_irq || trig !== m_trig) begin
            n_bad++;
            $display("FAIL %s: status=%b exp %b irq=%b exp %b trig=%b exp %b",
                     cur_req, status, m_st, irq, exp_irq, trig, m_trig);
        end
        ev_period = 0; ev_cmp_a = 0; ev_cmp_b = 0; ev_cap_a = 0; ev_cap_b = 0;
        ev_tstart = 0; ev_tstop = 0; ev_estop = 0; rd_a = 0; rd_b = 0;
        we = 0; addr = 0; wdata = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1; addr = a; wdata = d;
        cycle();
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, exp completion");
        if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst = 1; cycle(); cycle();
        rst = 0; cycle(); cycle();

        // R2: period status in every mode
        cur_req = "R2";
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            ev_period = 1; cycle(); cycle();
            wr(2'd1, 8'h01); cycle();
        end

        // R12: trigger stop/start status bits
        cur_req = "R12";
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            ev_tstop = 1; cycle();
            ev_tstart = 1; cycle();
            wr(2'd1, 8'h18);
        end

        // R3: channel A by mode
        cur_req = "R3";
        mode = 0; ev_cmp_a = 1; cycle(); wr(2'd1, 8'h02);
        mode = 2; ev_cmp_a = 1; cycle(); wr(2'd1, 8'h02);
        mode = 0; ev_cap_a = 1; cycle(); cycle();
        mode = 3; ev_cmp_a = 1; cycle(); cycle();
        ev_cap_a = 1; cycle(); wr(2'd1, 8'h02);

        // R4: channel B by mode, never in PWM2
        cur_req = "R4";
        mode = 2; ev_cmp_b = 1; cycle(); ev_cap_b = 1; cycle(); cycle();
        mode = 1; ev_cmp_b = 1; cycle(); wr(2'd1, 8'h04);
        mode = 3; ev_cmp_b = 1; cycle(); ev_cap_b = 1; cycle(); wr(2'd1, 8'h04);

        // R5: write-one-to-clear, zeros ignored
        cur_req = "R5";
        mode = 0; ev_period = 1; ev_tstop = 1; cycle();
        wr(2'd1, 8'h00); cycle();
        wr(2'd1, 8'h36); cycle();
        wr(2'd1, 8'h01); cycle();

        // R6: capture read strobes
        cur_req = "R6";
        mode = 3; ev_cap_a = 1; ev_cap_b = 1; cycle();
        rd_a = 1; cycle();
        rd_b = 1; cycle(); cycle();
        mode = 0; ev_cmp_a = 1; ev_cmp_b = 1; cycle();
        rd_a = 1; rd_b = 1; cycle(); cycle();
        wr(2'd1, 8'h06);

        // R7: enable gating of the request
        cur_req = "R7";
        ev_period = 1; cycle(); cycle();
        wr(2'd0, 8'h01); cycle();
        wr(2'd0, 8'h1e); cycle();
        ev_tstart = 1; cycle(); cycle();
        wr(2'd1, 8'h11); cycle();

        // R8: emergency stop follows function enable
        cur_req = "R8";
        wr(2'd0, 8'h00);
        estop_en = 0; ev_estop = 1; cycle(); cycle();
        estop_en = 1; cycle(); cycle();
        estop_en = 0; cycle();
        wr(2'd1, 8'h20); cycle();

        // R9: end-of-service acknowledge
        cur_req = "R9";
        wr(2'd0, 8'h01);
        ev_period = 1; cycle();
        wr(2'd3, 8'h01); cycle(); cycle();
        wr(2'd3, 8'h00); cycle();
        wr(2'd1, 8'h01);
        wr(2'd3, 8'h01); cycle();

        // R10: trigger pulse and its selection
        cur_req = "R10";
        wr(2'd2, 8'h07);
        ev_period = 1; cycle(); cycle();
        mode = 3; ev_cmp_a = 1; ev_cmp_b = 1; cycle(); cycle();
        mode = 2; ev_cmp_a = 1; cycle(); ev_cmp_b = 1; cycle(); cycle();
        mode = 1; ev_cmp_b = 1; cycle(); cycle();
        wr(2'd2, 8'h02);
        mode = 0; ev_period = 1; cycle(); ev_cmp_a = 1; cycle(); cycle();
        wr(2'd2, 8'h00);
        ev_period = 1; ev_cmp_a = 1; ev_cmp_b = 1; cycle(); cycle();
        wr(2'd1, 8'h3f);

        // R11: event beats clear in the same cycle
        cur_req = "R11";
        ev_period = 1; wr(2'd1, 8'h01); cycle();
        mode = 3; ev_cap_a = 1; rd_a = 1; cycle(); cycle();
        wr(2'd1, 8'h03); cycle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule